// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the register front end of a 24-pin interrupt redirection controller. Software reaches it through a small memory-mapped window with two live offsets. A write at the select offset stores the index of an internal register. A read or write at the data offset then reaches that internal register. The internal registers are the controller ID, the version word, the arbitration ID and the 64-bit redirection entries. Each entry is reached as two 32-bit halves.

The redirection table lives inside the block, and every entry is exported in parallel to the delivery logic. Two pieces of the surrounding logic stay outside: sampling the pins and sending messages. They talk to this block through a pin-request vector and a remote-pending set vector, which come in. Two one-cycle pulses go out. One reports that a write changed an entry's mask bit. The other is a reservice request for a level-triggered pin whose request is still active.

Top module: `irq_regwin`

## Requirements
- R1: Reset sets the mask bit (bit 16) of every entry and clears all other entry bits, the select register and the controller ID.
- R2: A write at offset 0x00 stores wdata[7:0] as the select value. A read at offset 0x00 returns that value, zero-extended.
- R3: With select 0x01, a window read (offset 0x10) returns (pin count − 1) in bits 23:16 and the version code in bits 7:0. All other bits read as zero.
- R4: The ID register and the arbitration-ID register read the same 4-bit ID in bits 27:24.
  - The ID register is at select 0x00 and the arbitration-ID register is at select 0x02.
  - A window write with select 0x00 loads wdata[27:24] into the ID.
  - Window writes with select 0x01 or 0x02 change nothing.
- R5: Select values of 0x10 and above address the table.
  - The entry index is (select − 0x10) >> 1.
  - Select bit 0 picks the upper half (1) or the lower half (0).
  - The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger 15 (1 = level), mask 16, destination 63:56.
- R6: A window write whose entry index is at or beyond the pin count changes no entry and raises no pulse. A window read of such an index returns zero.
- R7: A one-cycle pulse on rp_set[i] sets bit 14 of entry i.
  - A write to the lower half of an entry clears its bit 14, whatever the data holds.
  - A write to the upper half leaves bit 14 unchanged.
- R8: When a table write changes an entry's mask bit, mchg_vld pulses for one cycle one clock after the write. The pulse carries the pin index on mchg_pin and the new mask value on mchg_val. Without a change there is no pulse.
- R9: After a table write, svc_vld pulses for one cycle with svc_pin when both of these hold:
  - the entry's trigger bit is level after the write;
  - that pin's pin_req bit was set during the write.
- R10: Reads at offsets other than 0x00 and 0x10 return zero. Writes are accepted only with size 4 or 8. Only wdata[31:0] is used.
- R11: An access whose address bits above bit 7 differ from the base address is ignored. It causes no write and no rd_valid.
- R12: For an accepted read, rdata and rd_valid appear one clock after rd_en. rd_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 4 | Access size in bytes |
| wdata | input | 64 | Write data; low 32 bits used |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid pulse |
| pin_req | input | NPINS | Current pin request bits from the sampler |
| rp_set | input | NPINS | Set remote-pending bit of an entry |
| ent_table | output | NPINS*64 | All entries, entry i at bits i*64 +: 64 |
| ent_mask | output | NPINS | Mask bit of each entry |
| mchg_vld | output | 1 | Mask-change pulse |
| mchg_pin | output | PIN_W | Pin whose mask changed |
| mchg_val | output | 1 | New mask value |
| svc_vld | output | 1 | Reservice request pulse |
| svc_pin | output | PIN_W | Pin to reservice |

## Verification
The bench targets the table address arithmetic at the edges.

- The first pin, the last pin and the first index past the table are all tested. A design that used select − 0x10 without the shift, or let the out-of-range index alias onto entry 0, would corrupt a visible entry.
- Entries are written with bit 14 set in the data. A design that stored the data literally, or that cleared the flag on upper-half writes, shows the wrong remote-pending state.
- Writes are repeated with an unchanged mask. An edge-triggered entry is written with its pin request high. A design that pulsed on every write, or requested service without checking the trigger bit, would raise stray pulses.
- Sub-word writes, writes at unused offsets and writes outside the address range are each followed by a readback. A decoder that ignores size or upper address bits is caught there.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_SEL, ACC_WIN, ACC_OTHER} acc_t;
  localparam int ENT_W      = 64;
  localparam int B_REMOTE   = 14;
  localparam int B_TRIG     = 15;
  localparam int B_MASK     = 16;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output logic              in_rng,
  output logic              size_ok,
  output acc_t              kind
);
  assign in_rng  = (addr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);
  assign size_ok = (size == 4'd4) || (size == 4'd8);

  always_comb begin
    if (!in_rng)                 kind = ACC_NONE;
    else if (addr[7:0] == OFF_SEL) kind = ACC_SEL;
    else if (addr[7:0] == OFF_WIN) kind = ACC_WIN;
    else                         kind = ACC_OTHER;
  end
endmodule

// File: rtl/regwin_entry.sv
module regwin_entry
  import regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wd,
  input  logic             rp_set,
  output logic [ENT_W-1:0] q
);
  localparam logic [ENT_W-1:0] RST_VAL = ENT_W'(1) << B_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      if (wr_lo) begin
        q[31:0]     <= wd;
        q[B_REMOTE] <= 1'b0;
      end else if (rp_set) begin
        q[B_REMOTE] <= 1'b1;
      end
      if (wr_hi) q[63:32] <= wd;
    end
  end
endmodule

// File: rtl/regwin_events.sv
module regwin_events #(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tw,
  input  logic             hi,
  input  logic [PIN_W-1:0] pidx,
  input  logic             old_mask,
  input  logic             old_trig,
  input  logic             wd_mask,
  input  logic             wd_trig,
  input  logic             req,
  output logic             mchg_vld,
  output logic [PIN_W-1:0] mchg_pin,
  output logic             mchg_val,
  output logic             svc_vld,
  output logic [PIN_W-1:0] svc_pin
);
  logic new_mask, new_trig;
  assign new_mask = hi ? old_mask : wd_mask;
  assign new_trig = hi ? old_trig : wd_trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      mchg_vld <= 1'b0;
      mchg_pin <= '0;
      mchg_val <= 1'b0;
      svc_vld  <= 1'b0;
      svc_pin  <= '0;
    end else begin
      mchg_vld <= tw && (new_mask != old_mask);
      svc_vld  <= tw && new_trig && req;
      if (tw) begin
        mchg_pin <= pidx;
        mchg_val <= new_mask;
        svc_pin  <= pidx;
      end
    end
  end
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import regwin_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFEC0_0000,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int PIN_W  = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [3:0]             size,
  input  logic [63:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   rd_valid,
  input  logic [NPINS-1:0]       pin_req,
  input  logic [NPINS-1:0]       rp_set,
  output logic [NPINS*ENT_W-1:0] ent_table,
  output logic [NPINS-1:0]       ent_mask,
  output logic                   mchg_vld,
  output logic [PIN_W-1:0]       mchg_pin,
  output logic                   mchg_val,
  output logic                   svc_vld,
  output logic [PIN_W-1:0]       svc_pin
);
  localparam int SEL_W = 8;
  localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

  logic       in_rng, size_ok;
  acc_t       kind;
  logic       do_wr, do_rd, win_wr, tbl_wr;
  logic [SEL_W-1:0] sel_q, idx;
  logic       hi, idx_ok;
  logic [PIN_W-1:0] pidx;
  logic [3:0] id_q;
  logic [ENT_W-1:0] ent_arr [NPINS];
  logic [ENT_W-1:0] ent_cur;
  logic [31:0] rd_mux;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[63:32];

  regwin_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(addr), .size(size), .in_rng(in_rng), .size_ok(size_ok), .kind(kind)
  );

  assign do_wr  = wr_en && in_rng && size_ok;
  assign do_rd  = rd_en && in_rng;
  assign win_wr = do_wr && (kind == ACC_WIN);

  assign idx    = (sel_q - SEL_TBL) >> 1;
  assign hi     = sel_q[0];
  assign idx_ok = (sel_q >= SEL_TBL) && (idx < SEL_W'(NPINS));
  assign pidx   = idx_ok ? idx[PIN_W-1:0] : '0;
  assign tbl_wr = win_wr && idx_ok;
  assign ent_cur = ent_arr[pidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (do_wr && kind == ACC_SEL) sel_q <= wdata[SEL_W-1:0];
      if (win_wr && sel_q == SEL_ID) id_q <= wdata[27:24];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    regwin_entry u_ent (
      .clk(clk), .rst(rst),
      .wr_lo(tbl_wr && !hi && (pidx == PIN_W'(i))),
      .wr_hi(tbl_wr &&  hi && (pidx == PIN_W'(i))),
      .wd(wdata[31:0]),
      .rp_set(rp_set[i]),
      .q(ent_arr[i])
    );
    assign ent_table[i*ENT_W +: ENT_W] = ent_arr[i];
    assign ent_mask[i] = ent_arr[i][B_MASK];
  end

  regwin_events #(.PIN_W(PIN_W)) u_evt (
    .clk(clk), .rst(rst), .tw(tbl_wr), .hi(hi), .pidx(pidx),
    .old_mask(ent_cur[B_MASK]), .old_trig(ent_cur[B_TRIG]),
    .wd_mask(wdata[B_MASK]), .wd_trig(wdata[B_TRIG]),
    .req(pin_req[pidx]),
    .mchg_vld(mchg_vld), .mchg_pin(mchg_pin), .mchg_val(mchg_val),
    .svc_vld(svc_vld), .svc_pin(svc_pin)
  );

  always_comb begin
    rd_mux = '0;
    if (kind == ACC_SEL) begin
      rd_mux = {{(32-SEL_W){1'b0}}, sel_q};
    end else if (kind == ACC_WIN) begin
      if (sel_q == SEL_ID || sel_q == SEL_ARB) rd_mux = {4'h0, id_q, 24'h0};
      else if (sel_q == SEL_VER)               rd_mux = {8'h0, MAXPIN, 8'h0, VERSION};
      else if (idx_ok)                         rd_mux = hi ? ent_cur[63:32] : ent_cur[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic                 rd_valid,
  input logic [NPINS-1:0]     pin_req,
  input logic [NPINS*64-1:0]  ent_table,
  input logic [NPINS-1:0]     ent_mask,
  input logic                 mchg_vld,
  input logic [PIN_W-1:0]     mchg_pin,
  input logic                 mchg_val,
  input logic                 svc_vld,
  input logic [PIN_W-1:0]     svc_pin
);
  logic [NPINS-1:0] req_q;
  always_ff @(posedge clk) req_q <= pin_req;

  p_reset_masked_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&ent_mask));

  p_mchg_matches_r8: assert property (@(posedge clk) disable iff (rst)
    mchg_vld |-> (ent_mask[mchg_pin] == mchg_val));

  p_mchg_from_write_r8: assert property (@(posedge clk) disable iff (rst)
    mchg_vld |-> $past(wr_en));

  p_svc_level_r9: assert property (@(posedge clk) disable iff (rst)
    svc_vld |-> ($past(wr_en) && ent_table[svc_pin*64 + 15] && req_q[svc_pin]));

  p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind irq_regwin irq_regwin_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .pin_req(pin_req), .ent_table(ent_table), .ent_mask(ent_mask),
  .mchg_vld(mchg_vld), .mchg_pin(mchg_pin), .mchg_val(mchg_val),
  .svc_vld(svc_vld), .svc_pin(svc_pin)
);

// File: tb/sim_irq_regwin.sv
module sim_irq_regwin;
  localparam int NP = 24;
  localparam logic [31:0] BASE = 32'hFEC0_0000;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] addr = BASE;
  logic [3:0] size = 4;
  logic [63:0] wdata = 0;
  logic [31:0] rdata;
  logic rd_valid;
  logic [NP-1:0] pin_req = 0, rp_set = 0;
  logic [NP*64-1:0] ent_table;
  logic [NP-1:0] ent_mask;
  logic mchg_vld, mchg_val, svc_vld;
  logic [4:0] mchg_pin, svc_pin;

  int checks = 0, errors = 0;
  logic mc_v, mc_val, sv_v;
  logic [4:0] mc_p, sv_p;
  logic [31:0] rd_v;
  logic rd_ok;

  always #4 clk = ~clk;

  irq_regwin u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pin_req(pin_req),
    .rp_set(rp_set), .ent_table(ent_table), .ent_mask(ent_mask),
    .mchg_vld(mchg_vld), .mchg_pin(mchg_pin), .mchg_val(mchg_val),
    .svc_vld(svc_vld), .svc_pin(svc_pin)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [63:0] d, input logic [3:0] s = 4);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; size = s;
    @(posedge clk); #2;
    mc_v = mchg_vld; mc_p = mchg_pin; mc_val = mchg_val;
    sv_v = svc_vld;  sv_p = svc_pin;
    @(negedge clk);
    wr_en = 0; size = 4;
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(posedge clk); #2;
    rd_v = rdata; rd_ok = rd_valid;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [63:0] ent(input int i);
    return ent_table[i*64 +: 64];
  endfunction

  task automatic t_reset;
    chk(&ent_mask, "R1 masks", 64'(ent_mask), 64'hFFFFFF);
    chk(ent(0) == 64'h10000 && ent(NP-1) == 64'h10000, "R1 entry", ent(NP-1), 64'h10000);
    rd(BASE);
    chk(rd_v == 0, "R1 select", 64'(rd_v), 0);
    rd(BASE + 32'h10);
    chk(rd_v == 0, "R1 id", 64'(rd_v), 0);
  endtask

  task automatic t_select;
    wr(BASE, 64'h23);
    rd(BASE);
    chk(rd_v == 32'h23, "R2 readback", 64'(rd_v), 64'h23);
  endtask

  task automatic t_version;
    wr(BASE, 64'h01);
    rd(BASE + 32'h10);
    chk(rd_v == 32'h0017_0011, "R3 version", 64'(rd_v), 64'h00170011);
    chk(rd_ok, "R12 valid", 64'(rd_ok), 1);
    @(posedge clk); #2;
    chk(!rd_valid, "R12 single pulse", 64'(rd_valid), 0);
  endtask

  task automatic t_id;
    wr(BASE, 64'h00);
    wr(BASE + 32'h10, 64'hA500_0000);
    rd(BASE + 32'h10);
    chk(rd_v == 32'h0500_0000, "R4 id", 64'(rd_v), 64'h05000000);
    wr(BASE, 64'h02);
    wr(BASE + 32'h10, 64'hFFFF_FFFF);
    rd(BASE + 32'h10);
    chk(rd_v == 32'h0500_0000, "R4 arb", 64'(rd_v), 64'h05000000);
    wr(BASE, 64'h01);
    wr(BASE + 32'h10, 64'hFFFF_FFFF);
    rd(BASE + 32'h10);
    chk(rd_v == 32'h0017_0011, "R4 version ro", 64'(rd_v), 64'h00170011);
  endtask

  task automatic t_table;
    wr(BASE, 64'h1A);
    wr(BASE + 32'h10, 64'h0001_80AB);
    chk(!mc_v && !sv_v, "R5 no pulses", {mc_v, sv_v}, 0);
    wr(BASE, 64'h1B);
    wr(BASE + 32'h10, 64'hC000_0000);
    chk(ent(5) == 64'hC000_0000_0001_80AB, "R5 entry5", ent(5), 64'hC0000000000180AB);
    rd(BASE + 32'h10);
    chk(rd_v == 32'hC000_0000, "R5 hi read", 64'(rd_v), 64'hC0000000);
    wr(BASE, 64'h10 + 2*(NP-1));
    wr(BASE + 32'h10, 64'h0001_0077);
    chk(ent(NP-1) == 64'h0001_0077, "R5 last entry", ent(NP-1), 64'h10077);
    wr(BASE, 64'h10);
    wr(BASE + 32'h10, 64'h0001_0042);
    rd(BASE + 32'h10);
    chk(rd_v == 32'h0001_0042, "R5 entry0 lo", 64'(rd_v), 64'h10042);
  endtask

  task automatic t_oob;
    logic [NP*64-1:0] snap;
    snap = ent_table;
    wr(BASE, 64'h10 + 2*NP);
    wr(BASE + 32'h10, 64'h0000_0099);
    chk(ent_table == snap, "R6 table unchanged", ent(0), snap[63:0]);
    chk(!mc_v, "R6 no pulse", 64'(mc_v), 0);
    rd(BASE + 32'h10);
    chk(rd_v == 0, "R6 read zero", 64'(rd_v), 0);
  endtask

  task automatic t_remote;
    @(negedge clk); rp_set[3] = 1;
    @(negedge clk); rp_set[3] = 0;
    chk(ent(3)[14], "R7 set", ent(3), 64'h14000);
    wr(BASE, 64'h17);
    wr(BASE + 32'h10, 64'h1234_0000);
    chk(ent(3)[14], "R7 hi keeps", ent(3), 64'h12340000_00014000);
    wr(BASE, 64'h16);
    wr(BASE + 32'h10, 64'h0001_4000);
    chk(ent(3) == 64'h1234_0000_0001_0000, "R7 lo clears", ent(3), 64'h1234000000010000);
  endtask

  task automatic t_mask;
    wr(BASE, 64'h1E);
    wr(BASE + 32'h10, 64'h0000_0030);
    chk(mc_v && mc_p == 7 && !mc_val, "R8 unmask pulse", {mc_v, mc_p, mc_val}, {1'b1, 5'd7, 1'b0});
    @(posedge clk); #2;
    chk(!mchg_vld, "R8 one cycle", 64'(mchg_vld), 0);
    wr(BASE + 32'h10, 64'h0000_0031);
    chk(!mc_v, "R8 same mask", 64'(mc_v), 0);
    wr(BASE + 32'h10, 64'h0001_0031);
    chk(mc_v && mc_p == 7 && mc_val, "R8 mask pulse", {mc_v, mc_p, mc_val}, {1'b1, 5'd7, 1'b1});
  endtask

  task automatic t_svc;
    pin_req[9] = 1;
    wr(BASE, 64'h22);
    wr(BASE + 32'h10, 64'h0001_8040);
    chk(sv_v && sv_p == 9, "R9 level svc", {sv_v, sv_p}, {1'b1, 5'd9});
    wr(BASE + 32'h10, 64'h0001_0040);
    chk(!sv_v, "R9 edge no svc", 64'(sv_v), 0);
    pin_req[9] = 0;
    wr(BASE + 32'h10, 64'h0001_8040);
    chk(!sv_v, "R9 no request", 64'(sv_v), 0);
  endtask

  task automatic t_misc;
    rd(BASE + 32'h20);
    chk(rd_ok && rd_v == 0, "R10 other offset", 64'(rd_v), 0);
    wr(BASE, 64'h05);
    wr(BASE, 64'h44, 4'd2);
    rd(BASE);
    chk(rd_v == 32'h05, "R10 size2 ignored", 64'(rd_v), 5);
    wr(BASE + 32'h20, 64'h44);
    rd(BASE);
    chk(rd_v == 32'h05, "R10 other offset write", 64'(rd_v), 5);
    wr(BASE, 64'hFFFF_FFFF_0000_0011, 4'd8);
    rd(BASE);
    chk(rd_v == 32'h11, "R10 low 32 used", 64'(rd_v), 64'h11);
  endtask

  task automatic t_range;
    wr(BASE + 32'h100, 64'h33);
    rd(BASE);
    chk(rd_v == 32'h11, "R11 outside write", 64'(rd_v), 64'h11);
    rd(BASE - 32'h100);
    chk(!rd_ok, "R11 outside read", 64'(rd_ok), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset; t_select; t_version; t_id; t_table; t_oob;
        t_remote; t_mask; t_svc; t_misc; t_range;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule